// File: doc/BRIEF.md
# Asynchronous External Memory Timing Controller

This block runs single accesses on an asynchronous external memory bus of the SRAM, NOR or NAND kind, shared by several chip-selects. Each chip-select owns a 32-bit configuration word. The word sets the data-bus width and the lengths of the setup, strobe and hold phases, with separate values for reads and for writes. It also sets the count of idle turnaround cycles placed after each access. Every length is stored as the cycle count minus one.

The host issues one request at a time: chip-select index, direction, address and write data. It receives a one-cycle completion pulse, and on reads it receives the read data in that same cycle. Configuration words are written and read back through a small word-addressed port, where the word for chip-select `n` sits at byte offset `4*n`. The top two bits of each word are kept for two bus modes that this design never enables. They store and read back as written and have no effect on the bus.

The sequencer has five states. `ST_IDLE` moves to `ST_SETUP` when a request arrives. `ST_SETUP` moves to `ST_STROBE` when its count runs out. `ST_STROBE` moves to `ST_HOLD` at count end, and a read captures its data at that point. `ST_HOLD` moves to `ST_TURN` at count end and raises done in its last cycle. `ST_TURN` moves back to `ST_IDLE` at count end.

Top module: `async_mem_ctrl`

## Requirements
- R1: After reset, every chip-select, output-enable and write-enable line is high, done is low, `req_ready` is high, and every configuration word reads back as `RESET_CFG` (default `32'h3FFF_FFFC`).
- R2: A write on the configuration port at a byte offset with bits 1:0 zero and index (offset>>2) below `NUM_CS` replaces that chip-select's word, all 32 bits, including bits 31:30. Writes to any other offset are ignored, and readback of those offsets returns zero.
- R3: A read holds the chosen chip-select low for setup+1 cycles with output-enable high, then for strobe+1 cycles with output-enable low, then for hold+1 cycles with output-enable high. Read setup is taken from bits 16:13, read strobe from bits 12:7 and read hold from bits 6:4. Write-enable stays high throughout.
- R4: A write uses the same three phases, with write-enable low during the strobe. Write setup is taken from bits 29:26, write strobe from bits 25:20 and write hold from bits 19:17. Output-enable stays high throughout.
- R5: During a write, the data bus carries the write data in every cycle from the first setup cycle to the last hold cycle. The controller never drives the data bus while output-enable is low.
- R6: Read data is the bus value sampled in the last strobe cycle. It is presented on `rdata` while done is high.
- R7: `done` is high for exactly one cycle, the last hold cycle of each access.
- R8: After the hold phase, all chip-selects stay high for turnaround+1 cycles, with turnaround taken from bits 3:2. `req_ready` rises in the cycle after that.
- R9: A request is accepted only while `req_ready` is high. A request raised during an access starts no access, and the address stays stable for the whole access.
- R10: Bits 1:0 equal to 1 select a 16-bit bus. Any other value selects an 8-bit bus, in which case written data has bits 15:8 driven as zero and read data returns bits 15:8 as zero.
- R11: At most one chip-select is low at a time, and only the one named in the accepted request.
- R12: Bits 31:30 of a configuration word have no effect on phase lengths or on bus behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (5) | Configuration byte offset for write and readback |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback at cfg_addr |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W (2) | Chip-select index |
| req_addr | input | ADDR_W (16) | Access address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller idle, request may be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with done |
| mem_cs_n | output | NUM_CS (4) | Active-low chip-selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | ADDR_W (16) | Memory address |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
The bench counts strobe, chip-select and done positions cycle by cycle, with every field at zero and with fields near their maxima. An off-by-one in the minus-one encoding would stretch or shorten each phase by one cycle. The bench model drives the bus only while output-enable is low, so a controller that sampled read data in the hold phase would return the wrong value. It also raises a request in the middle of an access, which catches a controller that starts a second access or moves the address. Width codes 0 and 2 are both exercised, so treating any nonzero code as 16-bit would show up as non-zero upper bits.

// File: rtl/async_mem_pkg.sv
package async_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN
    } seq_state_t;

    typedef struct packed {
        logic [3:0] setup;
        logic [5:0] strobe;
        logic [2:0] hold;
        logic [1:0] turn;
        logic       wide;
    } phase_cfg_t;

    // Select the phase counts for one direction out of a configuration word.
    // Bits 31:30 are deliberately not looked at.
    function automatic phase_cfg_t pick_phases(input logic [31:0] word, input logic is_write);
        phase_cfg_t p;
        if (is_write) begin
            p.setup  = word[29:26];
            p.strobe = word[25:20];
            p.hold   = word[19:17];
        end else begin
            p.setup  = word[16:13];
            p.strobe = word[12:7];
            p.hold   = word[6:4];
        end
        p.turn = word[3:2];
        p.wide = (word[1:0] == 2'd1);
        return p;
    endfunction

endpackage

// File: rtl/async_mem_cfg_bank.sv
module async_mem_cfg_bank #(
    parameter int          NUM_CS    = 4,
    parameter int          CFG_AW    = 5,
    parameter logic [31:0] RESET_CFG = 32'h3FFF_FFFC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    output logic [NUM_CS-1:0][31:0] cfg_words
);
    localparam int IDX_W = CFG_AW - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;

    assign idx     = cfg_addr[CFG_AW-1:2];
    assign aligned = (cfg_addr[1:0] == 2'b00);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_words[g] <= RESET_CFG;
            end else if (cfg_we && aligned && (32'(idx) == g)) begin
                cfg_words[g] <= cfg_wdata;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (aligned && (32'(idx) < NUM_CS)) begin
            cfg_rdata = cfg_words[idx];
        end
    end

    // A write outside the mapped words must leave every word untouched.
    assert_ignore_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !(aligned && (32'(idx) < NUM_CS))) |=> $stable(cfg_words));

endmodule

// File: rtl/async_mem_seq.sv
module async_mem_seq
    import async_mem_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2,
    parameter int ADDR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [CS_W-1:0]         req_cs,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [15:0]             req_wdata,
    input  logic [NUM_CS-1:0][31:0] cfg_words,
    input  logic [15:0]             dq_in,
    output logic                    ready,
    output logic                    done,
    output logic [15:0]             rdata,
    output logic [NUM_CS-1:0]       cs_n,
    output logic                    oe_n,
    output logic                    we_n,
    output logic [ADDR_W-1:0]       addr,
    output logic [15:0]             dq_out,
    output logic                    dq_oe
);
    seq_state_t        state;
    logic [5:0]        cnt;
    logic              write_q;
    logic [CS_W-1:0]   cs_q;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       wdata_q;
    logic [15:0]       rdata_q;
    phase_cfg_t        ph_q;
    phase_cfg_t        ph_new;
    logic              last;
    logic              busy;

    assign ph_new = pick_phases(cfg_words[req_cs], req_write);
    assign last   = (cnt == 6'd0);

    // State register, counter and per-access latches.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            write_q <= 1'b0;
            cs_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            ph_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state   <= ST_SETUP;
                        cnt     <= 6'(ph_new.setup);
                        write_q <= req_write;
                        cs_q    <= req_cs;
                        addr_q  <= req_addr;
                        wdata_q <= ph_new.wide ? req_wdata : {8'h00, req_wdata[7:0]};
                        ph_q    <= ph_new;
                    end
                end
                ST_SETUP: begin
                    if (last) begin
                        state <= ST_STROBE;
                        cnt   <= ph_q.strobe;
                    end else begin
                        cnt <= cnt - 6'd1;
                    end
                end
                ST_STROBE: begin
                    if (last) begin
                        state <= ST_HOLD;
                        cnt   <= 6'(ph_q.hold);
                        if (!write_q) begin
                            rdata_q <= ph_q.wide ? dq_in : {8'h00, dq_in[7:0]};
                        end
                    end else begin
                        cnt <= cnt - 6'd1;
                    end
                end
                ST_HOLD: begin
                    if (last) begin
                        state <= ST_TURN;
                        cnt   <= 6'(ph_q.turn);
                    end else begin
                        cnt <= cnt - 6'd1;
                    end
                end
                ST_TURN: begin
                    if (last) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 6'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Pin and host outputs decoded from the current state.
    always_comb begin
        busy   = 1'b0;
        cs_n   = '1;
        oe_n   = 1'b1;
        we_n   = 1'b1;
        dq_oe  = 1'b0;
        done   = 1'b0;
        ready  = 1'b0;
        unique case (state)
            ST_IDLE:   ready = 1'b1;
            ST_SETUP:  busy  = 1'b1;
            ST_STROBE: begin
                busy = 1'b1;
                oe_n = write_q;
                we_n = !write_q;
            end
            ST_HOLD: begin
                busy = 1'b1;
                done = last;
            end
            ST_TURN:   busy = 1'b0;
            default:   ready = 1'b0;
        endcase
        if (busy) begin
            cs_n[cs_q] = 1'b0;
            dq_oe      = write_q;
        end
    end

    assign addr   = addr_q;
    assign dq_out = wdata_q;
    assign rdata  = rdata_q;

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ready) |=> (!busy || $stable(addr)));

    assert_turn_idle_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN) |-> (&cs_n && oe_n && we_n));

    assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !last) |=> (state == ST_HOLD));

endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl #(
    parameter int          NUM_CS    = 4,
    parameter int          ADDR_W    = 16,
    parameter int          CFG_AW    = 5,
    parameter logic [31:0] RESET_CFG = 32'h3FFF_FFFC,
    localparam int         CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [15:0]       rdata,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [15:0]       mem_dq
);
    logic [NUM_CS-1:0][31:0] cfg_words;
    logic [15:0]             dq_out;
    logic                    dq_oe;

    async_mem_cfg_bank #(
        .NUM_CS    (NUM_CS),
        .CFG_AW    (CFG_AW),
        .RESET_CFG (RESET_CFG)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_words (cfg_words)
    );

    async_mem_seq #(
        .NUM_CS (NUM_CS),
        .CS_W   (CS_W),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cs    (req_cs),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cfg_words (cfg_words),
        .dq_in     (mem_dq),
        .ready     (req_ready),
        .done      (done),
        .rdata     (rdata),
        .cs_n      (mem_cs_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .addr      (mem_addr),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    assign mem_dq = dq_oe ? dq_out : 16'hzzzz;

    assert_single_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> mem_oe_n);

    assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

endmodule

// File: tb/async_mem_ctrl_tb.sv
module async_mem_ctrl_tb;
    localparam int CLK_P = 10;
    localparam logic [31:0] RST_WORD = 32'h3FFF_FFFC;

    typedef struct packed {
        logic [1:0]  cs;
        logic        wr;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [1:0]  ta;
        logic [2:0]  rh;
        logic [5:0]  rt;
        logic [3:0]  rs;
        logic [2:0]  wh;
        logic [5:0]  wt;
        logic [3:0]  ws;
        logic [1:0]  bw;
        logic [1:0]  rsv;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b0, 16'h1234, 16'h0000, 2'd1, 3'd1, 6'd3,  4'd2,  3'd2, 6'd4,  4'd1,  2'd1, 2'd0},
        '{2'd0, 1'b1, 16'h2222, 16'hBEEF, 2'd1, 3'd1, 6'd3,  4'd2,  3'd2, 6'd4,  4'd1,  2'd1, 2'd0},
        '{2'd1, 1'b0, 16'h00F0, 16'h0000, 2'd0, 3'd0, 6'd0,  4'd0,  3'd0, 6'd0,  4'd0,  2'd0, 2'd0},
        '{2'd1, 1'b1, 16'h0F0F, 16'hCAFE, 2'd0, 3'd0, 6'd0,  4'd0,  3'd0, 6'd0,  4'd0,  2'd0, 2'd0},
        '{2'd2, 1'b0, 16'hA5A5, 16'h0000, 2'd3, 3'd7, 6'd10, 4'd5,  3'd7, 6'd63, 4'd15, 2'd1, 2'd3},
        '{2'd2, 1'b1, 16'h5A5A, 16'h1357, 2'd3, 3'd7, 6'd10, 4'd5,  3'd7, 6'd63, 4'd15, 2'd1, 2'd3},
        '{2'd3, 1'b1, 16'h7777, 16'hABCD, 2'd2, 3'd3, 6'd1,  4'd3,  3'd4, 6'd2,  4'd6,  2'd2, 2'd0},
        '{2'd3, 1'b0, 16'h8001, 16'h0000, 2'd2, 3'd3, 6'd1,  4'd3,  3'd4, 6'd2,  4'd6,  2'd2, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic        done;
    logic [15:0] rdata;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic [15:0] mem_addr;
    wire  [15:0] mem_dq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Memory model: answers only while output-enable is low.
    logic        model_en;
    logic [15:0] model_val;
    assign model_en  = !mem_oe_n && !(&mem_cs_n);
    assign model_val = mem_addr ^ 16'h5A3C;
    assign mem_dq    = model_en ? model_val : 16'hzzzz;

    always #(CLK_P/2) clk = ~clk;

    async_mem_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cs    (req_cs),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .done      (done),
        .rdata     (rdata),
        .mem_cs_n  (mem_cs_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_addr  (mem_addr),
        .mem_dq    (mem_dq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input vec_t v);
        return {v.rsv, v.ws, v.wt, v.wh, v.rs, v.rt, v.rh, v.ta, v.bw};
    endfunction

    task automatic prog(input logic [4:0] a, input logic [31:0] w);
        @(negedge clk);
        cfg_addr  = a;
        cfg_wdata = w;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic readback(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    // Run one access and compare every observed phase position with the
    // values derived from the configuration word. poke raises a competing
    // request in the middle of the access.
    task automatic run_access(input logic [1:0] cs, input logic wr, input logic [15:0] a,
                              input logic [15:0] wd, input logic [31:0] word, input bit poke);
        int s, t, h, ta, n;
        int k_done, k_ready, k_str_first, n_str, n_cs, n_other_strobe, n_wrong_cs, n_bad_dq;
        bit wide;
        logic [15:0] exp_rd, exp_wd, got_rd;
        s    = wr ? int'(word[29:26]) : int'(word[16:13]);
        t    = wr ? int'(word[25:20]) : int'(word[12:7]);
        h    = wr ? int'(word[19:17]) : int'(word[6:4]);
        ta   = int'(word[3:2]);
        wide = (word[1:0] == 2'd1);
        n    = s + t + h + 3;
        exp_rd = wide ? (a ^ 16'h5A3C) : {8'h00, (a[7:0] ^ 8'h3C)};
        exp_wd = wide ? wd : {8'h00, wd[7:0]};
        k_done = -1; k_ready = -1; k_str_first = -1;
        n_str = 0; n_cs = 0; n_other_strobe = 0; n_wrong_cs = 0; n_bad_dq = 0;
        got_rd = '0;
        @(negedge clk);
        req_cs = cs; req_write = wr; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        for (int k = 1; k < 400; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (poke && k == 3) begin
                req_valid = 1'b1; req_write = ~wr; req_cs = cs + 2'd1; req_addr = ~a;
            end
            if (poke && k == 4) req_valid = 1'b0;
            if (!mem_cs_n[cs]) n_cs++;
            if ((~mem_cs_n & ~(4'b0001 << cs)) != 4'b0000) n_wrong_cs++;
            if (wr ? !mem_we_n : !mem_oe_n) begin
                n_str++;
                if (k_str_first < 0) k_str_first = k;
            end
            if (wr ? !mem_oe_n : !mem_we_n) n_other_strobe++;
            if (wr && !mem_cs_n[cs] && mem_dq !== exp_wd) n_bad_dq++;
            if (done) begin
                if (k_done < 0) begin
                    k_done = k;
                    got_rd = rdata;
                end else begin
                    k_done = 1000;
                end
            end
            if (k_done > 0 && req_ready) begin
                k_ready = k;
                break;
            end
        end
        check(n_cs == n, "R3/R4 chip-select low cycles", n_cs, n);
        check(k_str_first == s + 2, wr ? "R4 strobe start" : "R3 strobe start", k_str_first, s + 2);
        check(n_str == t + 1, wr ? "R4 strobe length" : "R3 strobe length", n_str, t + 1);
        check(n_other_strobe == 0, "R3/R4 opposite strobe stays high", n_other_strobe, 0);
        check(k_done == n, "R7 done position", k_done, n);
        check(k_ready == n + ta + 2, "R8 turnaround before ready", k_ready, n + ta + 2);
        check(n_wrong_cs == 0, "R11 only selected chip-select", n_wrong_cs, 0);
        if (wr) check(n_bad_dq == 0, "R5 R10 write data on bus", n_bad_dq, 0);
        else    check(got_rd == exp_rd, "R6 R10 read data", got_rd, exp_rd);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of pins and host side
        check(mem_cs_n == 4'hF, "R1 chip-selects high", mem_cs_n, 4'hF);
        check(mem_oe_n && mem_we_n, "R1 strobes high", {mem_oe_n, mem_we_n}, 2'b11);
        check(!done && req_ready, "R1 done low ready high", {done, req_ready}, 2'b01);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) readback(5'(i * 4), RST_WORD, "R1 reset configuration");

        // Access using the reset configuration (slowest timings).
        run_access(2'd2, 1'b0, 16'h0101, 16'h0000, RST_WORD, 1'b0);

        // R2: unmapped and misaligned writes are ignored
        prog(5'h10, 32'h1234_5678);
        prog(5'h01, 32'h8765_4321);
        readback(5'h00, RST_WORD, "R2 misaligned write ignored");
        readback(5'h10, 32'h0, "R2 unmapped readback zero");

        // Table walk: program the chip-select, check readback, run the access.
        for (int i = 0; i < NV; i++) begin
            prog(5'(TBL[i].cs * 4), mk_word(TBL[i]));
            readback(5'(TBL[i].cs * 4), mk_word(TBL[i]), "R2 readback incl bits 31:30");
            run_access(TBL[i].cs, TBL[i].wr, TBL[i].addr, TBL[i].wdata, mk_word(TBL[i]), 1'b0);
        end

        // R12: same fields with bits 31:30 cleared give identical timing.
        prog(5'h08, mk_word(TBL[4]) & 32'h3FFF_FFFF);
        run_access(2'd2, 1'b0, 16'hA5A5, 16'h0, mk_word(TBL[4]) & 32'h3FFF_FFFF, 1'b0);
        prog(5'h08, mk_word(TBL[4]));
        run_access(2'd2, 1'b0, 16'hA5A5, 16'h0, mk_word(TBL[4]), 1'b0);

        // R9: request raised mid-access must start nothing.
        prog(5'h00, mk_word(TBL[0]));
        run_access(2'd0, 1'b0, 16'h4321, 16'h0, mk_word(TBL[0]), 1'b1);
        begin
            int extra;
            extra = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (mem_cs_n != 4'hF || done || !req_ready) extra++;
            end
            check(extra == 0, "R9 busy request ignored", extra, 0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule